// File: doc/BRIEF.md
# Burst Address Sequence Counter

This block produces the low-order word address for each beat of a four-beat burst in a synchronous pipelined SRAM. When an access starts, a load strobe captures the two-bit starting word address, the upper address bits and the ordering strap. The captured start address appears on the output after that clock edge and serves the first beat. Each later edge at which the active-low advance input is low moves the burst on by one beat. When the advance input is high, the current address is held.

The strap chooses between two orders. Linear order adds the beat number to the start address modulo four. Interleaved order XORs the start address with the beat number. The strap is meant to stay at one level. A board that leaves it undriven must pull it high, so that the default order is interleaved. The block samples the strap only at a load, so a strap that moves during a burst cannot change that burst's order. Only the beat counter moves. The upper address bits are passed through as captured and never receive a carry. The reset input is asynchronous on assertion, and its release is synchronised to the clock inside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and until the first load after reset, `addr_o` is all zeros.
- R2: On a clock edge with `load_i` high, the next value of `addr_o` is {`upper_i`, `start_i`} as presented at that edge.
- R3: On a clock edge with `load_i` low and `adv_n_i` high, `addr_o` keeps its value.
- R4: With `mode_i` = 0 captured at the load, beat n of the burst presents low bits (start + n) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R5: With `mode_i` = 1 captured at the load, beat n presents low bits start XOR n. For example, start 1 gives 1, 0, 3, 2.
- R6: When `load_i` is high and `adv_n_i` is low at the same edge, the load wins and the first beat of the new burst is presented.
- R7: Advances after the fourth beat wrap within the same four-word group. The fifth beat equals the start address, and the upper bits of `addr_o` never change between loads.
- R8: `mode_i` is sampled only at a load. Changing it in the middle of a burst leaves that burst's order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset: asynchronous assertion, synchronised release |
| load_i | input | 1 | Starts a burst by capturing the start address, the upper bits and the strap |
| start_i | input | BEAT_W (2) | Starting word address within the group |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Order strap: 0 selects linear, 1 selects interleaved (pull high when undriven) |
| upper_i | input | UPPER_W (8) | Upper address bits, passed through |
| addr_o | output | UPPER_W+BEAT_W (10) | Current burst address: {upper, low word} |

## Verification
A stuck or mis-stepped beat counter shows up on the low bits of `addr_o` one cycle after the first advance that should have moved it. Linear and interleaved orders agree for some start addresses and differ for others, so mixed start values are needed to separate them within the second beat. A strap captured at the wrong moment appears only when the strap toggles mid-burst, and then on the next advance. A carry leaking into the upper field shows at the wrap, on the fifth beat of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bseq_start_reg.sv
module bseq_start_reg
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W  = 2,
  parameter int UPPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [BEAT_W-1:0]  start_i,
  input  logic [UPPER_W-1:0] upper_i,
  input  logic               mode_i,
  output logic [BEAT_W-1:0]  start_q,
  output logic [UPPER_W-1:0] upper_q,
  output order_e             order_q
);

  logic [BEAT_W-1:0]  start_d;
  logic [UPPER_W-1:0] upper_d;
  order_e             order_d;

  always_comb begin
    start_d = start_q;
    upper_d = upper_q;
    order_d = order_q;
    if (load_i) begin
      start_d = start_i;
      upper_d = upper_i;
      order_d = mode_i ? ORD_INTERLEAVED : ORD_LINEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      upper_q <= '0;
      order_q <= ORD_INTERLEAVED;
    end else begin
      start_q <= start_d;
      upper_q <= upper_d;
      order_q <= order_d;
    end
  end

endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_n_i,
  output logic [BEAT_W-1:0] beat_q
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_d;
  logic              cnt_en;

  assign cnt_en = load_i | ~adv_n_i;

  always_comb begin
    beat_d = beat_q;
    if (load_i) begin
      beat_d = '0;
    end else if (!adv_n_i) begin
      beat_d = beat_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (cnt_en) begin
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] word_o
);

  logic [BEAT_W-1:0] lin_word;
  logic [BEAT_W-1:0] ilv_word;

  assign lin_word = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
    assign ilv_word[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    case (order_i)
      ORD_LINEAR:      word_o = lin_word;
      ORD_INTERLEAVED: word_o = ilv_word;
      default:         word_o = ilv_word;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W  = 2,
  parameter int UPPER_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [BEAT_W-1:0]         start_i,
  input  logic                      adv_n_i,
  input  logic                      mode_i,
  input  logic [UPPER_W-1:0]        upper_i,
  output logic [UPPER_W+BEAT_W-1:0] addr_o
);

  localparam int ADDR_W = UPPER_W + BEAT_W;

  logic               rst_int_n;
  logic [BEAT_W-1:0]  start_q;
  logic [UPPER_W-1:0] upper_q;
  order_e             order_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  word;
  logic [ADDR_W-1:0]  addr_w;

  bseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bseq_start_reg #(.BEAT_W(BEAT_W), .UPPER_W(UPPER_W)) u_start (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load_i),
    .start_i (start_i),
    .upper_i (upper_i),
    .mode_i  (mode_i),
    .start_q (start_q),
    .upper_q (upper_q),
    .order_q (order_q)
  );

  bseq_beat_cnt #(.BEAT_W(BEAT_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load_i),
    .adv_n_i (adv_n_i),
    .beat_q  (beat_q)
  );

  bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order_q),
    .word_o  (word)
  );

  assign addr_w = {upper_q, word};
  assign addr_o = addr_w;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int BEAT_W  = 2,
  parameter int UPPER_W = 8
) (
  input logic                      clk,
  input logic                      rst_ok_n,
  input logic                      load_i,
  input logic [BEAT_W-1:0]         start_i,
  input logic                      adv_n_i,
  input logic [UPPER_W-1:0]        upper_i,
  input logic [UPPER_W+BEAT_W-1:0] addr_o,
  input logic                      mode_cap
);

  logic [BEAT_W-1:0]  lo_w;
  logic [UPPER_W-1:0] hi_w;

  assign lo_w = addr_o[BEAT_W-1:0];
  assign hi_w = addr_o[UPPER_W+BEAT_W-1:BEAT_W];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    load_i |=> (lo_w == $past(start_i)) && (hi_w == $past(upper_i))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!load_i && adv_n_i) |=> $stable(addr_o)); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!load_i && !adv_n_i && !mode_cap) |=> (lo_w == BEAT_W'($past(lo_w) + 1'b1))); // R4

  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!load_i && !adv_n_i && mode_cap) |=> (lo_w[0] != $past(lo_w[0]))); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (load_i && !adv_n_i) |=> (lo_w == $past(start_i))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !load_i |=> $stable(hi_w)); // R7

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !load_i |=> $stable(mode_cap)); // R8

endmodule

bind burst_addr_seq bseq_checker #(.BEAT_W(BEAT_W), .UPPER_W(UPPER_W)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_int_n),
  .load_i   (load_i),
  .start_i  (start_i),
  .adv_n_i  (adv_n_i),
  .upper_i  (upper_i),
  .addr_o   (addr_o),
  .mode_cap (order_q == burst_seq_pkg::ORD_INTERLEAVED)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 2;
  localparam int UW = 8;
  localparam int AW = BW + UW;

  logic          clk;
  logic          rst_n;
  logic          load_i;
  logic [BW-1:0] start_i;
  logic          adv_n_i;
  logic          mode_i;
  logic [UW-1:0] upper_i;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  logic [BW-1:0] m_start;
  logic [UW-1:0] m_upper;
  logic          m_mode;
  logic [BW-1:0] m_beat;

  burst_addr_seq #(.BEAT_W(BW), .UPPER_W(UW)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_n_i (adv_n_i),
    .mode_i  (mode_i),
    .upper_i (upper_i),
    .addr_o  (addr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [BW-1:0] exp_word(logic [BW-1:0] s, logic [BW-1:0] n, logic m);
    logic [BW-1:0] r;
    if (m) r = s ^ n;
    else   r = BW'(s + n);
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_upper, exp_word(m_start, m_beat, m_mode)};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_o actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, logic ld, logic [BW-1:0] st, logic advn,
                      logic md, logic [UW-1:0] up);
    @(negedge clk);
    load_i = ld; start_i = st; adv_n_i = advn; mode_i = md; upper_i = up;
    @(posedge clk);
    if (ld) begin
      m_start = st; m_upper = up; m_mode = md; m_beat = '0;
    end else if (!advn) begin
      m_beat = BW'(m_beat + 1'b1);
    end
    #1;
    check(req, addr_o, exp_addr());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run hung actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    load_i = 0; start_i = '0; adv_n_i = 1; mode_i = 1; upper_i = '0;
    m_start = '0; m_upper = '0; m_mode = 1'b1; m_beat = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", addr_o, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R1 after release", addr_o, '0);

    // R4 and R7: linear from 2, wrapping back to 2
    step("R2 load linear", 1, 2'd2, 1, 0, 8'h3C);
    check("R2 start beat", addr_o, {8'h3C, 2'd2});
    for (int i = 0; i < 4; i++) step("R4 linear beat", 0, 2'd0, 0, 0, 8'h00);
    check("R7 linear wrap", addr_o, {8'h3C, 2'd2});

    // R5 and R7: interleaved from 1
    step("R2 load interleaved", 1, 2'd1, 1, 1, 8'hFF);
    step("R5 interleaved b1", 0, 2'd0, 0, 1, 8'h00);
    check("R5 beat1 is 0", addr_o, {8'hFF, 2'd0});
    step("R5 interleaved b2", 0, 2'd0, 0, 1, 8'h00);
    check("R5 beat2 is 3", addr_o, {8'hFF, 2'd3});
    step("R5 interleaved b3", 0, 2'd0, 0, 1, 8'h00);
    step("R7 interleaved wrap", 0, 2'd0, 0, 1, 8'h00);
    check("R7 upper kept at all ones", addr_o, {8'hFF, 2'd1});

    // R3: hold with advance deasserted
    step("R3 load", 1, 2'd3, 1, 0, 8'h11);
    step("R3 one advance", 0, 2'd0, 0, 0, 8'h00);
    for (int i = 0; i < 3; i++) step("R3 hold", 0, 2'd2, 1, 1, 8'hAA);
    check("R3 held value", addr_o, {8'h11, 2'd0});

    // R6: load and advance together
    step("R6 advance", 0, 2'd0, 0, 0, 8'h00);
    step("R6 load wins", 1, 2'd1, 0, 0, 8'h5A);
    check("R6 first beat", addr_o, {8'h5A, 2'd1});

    // R8: strap toggles mid-burst, order stays linear
    step("R8 load linear", 1, 2'd1, 1, 0, 8'h22);
    step("R8 adv with mode high", 0, 2'd0, 0, 1, 8'h00);
    check("R8 linear b1", addr_o, {8'h22, 2'd2});
    step("R8 adv with mode high", 0, 2'd0, 0, 1, 8'h00);
    check("R8 linear b2", addr_o, {8'h22, 2'd3});

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic ld;
      ld = (($urandom % 5) == 0);
      step(ld ? "R2 random load" : "R4 R5 R3 random beat", ld,
           BW'($urandom), logic'($urandom % 2), logic'($urandom % 2), UW'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule